// File: doc/BRIEF.md
# Transmit Start Threshold Gate

This block decides the moment at which a MAC transmit path is allowed to begin draining a frame from its transmit FIFO. It watches the FIFO fill level, counted in 32-bit words, together with a flag that says a whole frame is already buffered. It raises a registered start grant once the configured start condition holds. The grant then stays high until the transmit side reports that the frame is done.

Two start policies are available. In cut-through operation, a 2-bit level code picks a word threshold, and the fill level must reach it. The code is read against one of two four-entry tables, chosen by the link-speed select: one table for the slow link and one for the fast link. In store-and-forward operation, the fill level is ignored and the grant waits for the complete-frame flag. In both policies a complete frame always releases the grant, so a frame shorter than the threshold still goes out.

The level code, the speed select and the store-and-forward enable are captured into a small configuration register on a load strobe. The grant decision reads only that register, so a setting loaded while a frame is being sent applies to the next frame.

Top module: `tx_start_gate`

## Requirements
- R1: After reset the grant is 0 and the captured configuration is level code 00, fast link (speed select 0) and store-and-forward off, so a fill level of 0x20 words opens the grant and 0x1F does not.
- R2: With speed select 1 (slow link), level codes 00, 01, 10 and 11 select thresholds of 18, 24, 32 and 40 words.
- R3: With speed select 0 (fast link), level codes 00, 01, 10 and 11 select thresholds of 32, 64, 128 and 256 words.
- R4: With store-and-forward off and the grant low, the grant rises at the first clock edge at which the fill level is greater than or equal to the threshold, and not while the fill level is one word below it.
- R5: With store-and-forward on and the grant low, the grant rises at the first clock edge at which the complete-frame flag is 1, and stays low while the flag is 0, whatever the fill level.
- R6: With store-and-forward off, a complete-frame flag of 1 opens the grant even when the fill level is below the threshold.
- R7: Once high, the grant stays high until a clock edge at which frame-done is 1, and it is 0 after that edge; frame-done has no effect while the grant is low.
- R8: A configuration loaded while the grant is high does not change the grant, and it sets the threshold used for the next frame.
- R9: The level code, speed select and store-and-forward enable take effect only at a clock edge with the load strobe at 1; changes on those inputs without the strobe have no effect on the grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_load | input | 1 | Captures the three configuration inputs at the clock edge |
| cfg_level | input | 2 | Threshold level code |
| cfg_slow | input | 1 | Speed select: 1 slow link table, 0 fast link table |
| cfg_sf | input | 1 | Store-and-forward enable |
| fill_words | input | FILL_W (10) | Current FIFO fill level in 32-bit words |
| frame_ready | input | 1 | A complete frame is buffered |
| frame_done | input | 1 | The current frame has left the FIFO |
| start_grant | output | 1 | Registered permission to start transmitting |

## Verification
A configuration load is registered at one clock edge and governs the grant decision made at the next edge. The grant itself follows its condition by exactly one edge, and frame-done drops it at the edge where the strobe is seen. The bench drives every input after a falling edge and advances its own reference model at the rising edge, using the configuration the model held before that edge. It compares the grant at the following falling edge, so each result is checked in the cycle in which the register chain makes it due. Directed sequences place the fill level at one word below each table entry and then exactly at it, for both speeds.

// File: rtl/txg_pkg.sv
package txg_pkg;

  localparam int unsigned LEVEL_W   = 2;
  localparam int unsigned NUM_LEVEL = 1 << LEVEL_W;

  typedef enum logic {
    GATE_IDLE = 1'b0,
    GATE_OPEN = 1'b1
  } gate_state_e;

  typedef struct packed {
    logic [LEVEL_W-1:0] level;
    logic               slow;
    logic               sf;
  } txg_cfg_t;

  // Slow link start levels in words, indexed by level code.
  function automatic int unsigned slow_words(input int unsigned idx);
    case (idx)
      0:       return 18;
      1:       return 24;
      2:       return 32;
      default: return 40;
    endcase
  endfunction

  // Fast link start levels double with each code step from 32 words.
  function automatic int unsigned fast_words(input int unsigned idx);
    return 32 << idx;
  endfunction

endpackage

// File: rtl/txg_rst_sync.sv
module txg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/txg_cfg_reg.sv
module txg_cfg_reg
  import txg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [LEVEL_W-1:0] level_in,
  input  logic               slow_in,
  input  logic               sf_in,
  output txg_cfg_t           cfg
);

  txg_cfg_t cfg_q;
  txg_cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (load) begin
      cfg_d.level = level_in;
      cfg_d.slow  = slow_in;
      cfg_d.sf    = sf_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (load) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg = cfg_q;

  // Without a load strobe the captured settings hold.
  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cfg_q));

endmodule

// File: rtl/txg_thresh_lut.sv
module txg_thresh_lut
  import txg_pkg::*;
#(
  parameter int unsigned FILL_W = 10
) (
  input  logic [LEVEL_W-1:0] level,
  input  logic               slow,
  output logic [FILL_W-1:0]  thresh
);

  logic [FILL_W-1:0] slow_tbl [NUM_LEVEL];
  logic [FILL_W-1:0] fast_tbl [NUM_LEVEL];

  for (genvar i = 0; i < NUM_LEVEL; i++) begin : g_tbl
    assign slow_tbl[i] = FILL_W'(slow_words(i));
    assign fast_tbl[i] = FILL_W'(fast_words(i));
  end

  always_comb begin
    if (slow) begin
      thresh = slow_tbl[level];
    end else begin
      thresh = fast_tbl[level];
    end
  end

endmodule

// File: rtl/txg_grant_fsm.sv
module txg_grant_fsm
  import txg_pkg::*;
#(
  parameter int unsigned FILL_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sf_mode,
  input  logic [FILL_W-1:0] thresh,
  input  logic [FILL_W-1:0] fill_words,
  input  logic              frame_ready,
  input  logic              frame_done,
  output logic              grant
);

  gate_state_e state_q;
  gate_state_e state_d;
  logic        level_met;
  logic        start_ok;

  always_comb begin
    level_met = (fill_words >= thresh);
    if (sf_mode) begin
      start_ok = frame_ready;
    end else begin
      start_ok = frame_ready | level_met;
    end
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      GATE_IDLE: if (start_ok)   state_d = GATE_OPEN;
      GATE_OPEN: if (frame_done) state_d = GATE_IDLE;
      default:                   state_d = GATE_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GATE_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign grant = (state_q == GATE_OPEN);

  // A rising grant needs the start condition one edge earlier.
  assert_rise_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant) |-> ($past(frame_ready) ||
                      (!$past(sf_mode) && ($past(fill_words) >= $past(thresh)))));

  assert_sf_waits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant && sf_mode && !frame_ready) |=> !grant);

  assert_hold_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !frame_done) |=> grant);

  assert_done_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && frame_done) |=> !grant);

endmodule

// File: rtl/tx_start_gate.sv
module tx_start_gate
  import txg_pkg::*;
#(
  parameter int unsigned FILL_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [1:0]        cfg_level,
  input  logic              cfg_slow,
  input  logic              cfg_sf,
  input  logic [FILL_W-1:0] fill_words,
  input  logic              frame_ready,
  input  logic              frame_done,
  output logic              start_grant
);

  logic              rst_n_s;
  txg_cfg_t          cfg;
  logic [FILL_W-1:0] thresh;

  txg_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  txg_cfg_reg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load     (cfg_load),
    .level_in (cfg_level),
    .slow_in  (cfg_slow),
    .sf_in    (cfg_sf),
    .cfg      (cfg)
  );

  txg_thresh_lut #(.FILL_W(FILL_W)) u_lut (
    .level  (cfg.level),
    .slow   (cfg.slow),
    .thresh (thresh)
  );

  txg_grant_fsm #(.FILL_W(FILL_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .sf_mode     (cfg.sf),
    .thresh      (thresh),
    .fill_words  (fill_words),
    .frame_ready (frame_ready),
    .frame_done  (frame_done),
    .grant       (start_grant)
  );

endmodule

// File: tb/test_tx_start_gate.sv
`timescale 1ns/1ps
module test_tx_start_gate;

  localparam int unsigned FW = 10;

  logic          clk;
  logic          rst_n;
  logic          cfg_load;
  logic [1:0]    cfg_level;
  logic          cfg_slow;
  logic          cfg_sf;
  logic [FW-1:0] fill_words;
  logic          frame_ready;
  logic          frame_done;
  logic          start_grant;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  // reference model state
  logic [1:0] m_level;
  logic       m_slow;
  logic       m_sf;
  logic       m_grant;

  tx_start_gate #(.FILL_W(FW)) i_tx_start_gate (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_level(cfg_level),
    .cfg_slow(cfg_slow), .cfg_sf(cfg_sf), .fill_words(fill_words),
    .frame_ready(frame_ready), .frame_done(frame_done), .start_grant(start_grant)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int unsigned thr_of(input logic [1:0] lv, input logic slow);
    if (slow) begin
      case (lv)
        2'd0: return 18;
        2'd1: return 24;
        2'd2: return 32;
        default: return 40;
      endcase
    end
    case (lv)
      2'd0: return 32;
      2'd1: return 64;
      2'd2: return 128;
      default: return 256;
    endcase
  endfunction

  function automatic logic next_grant();
    if (m_grant) return !frame_done;
    if (m_sf) return frame_ready;
    return frame_ready || (int'(fill_words) >= int'(thr_of(m_level, m_slow)));
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: start_grant=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock: model advances at the rising edge, compare at the falling edge.
  task automatic tick(input string tag);
    logic ng;
    @(posedge clk);
    ng = next_grant();
    if (cfg_load) begin
      m_level = cfg_level;
      m_slow  = cfg_slow;
      m_sf    = cfg_sf;
    end
    m_grant = ng;
    @(negedge clk);
    check(tag, start_grant, m_grant);
  endtask

  task automatic idle_inputs();
    cfg_load = 0; frame_ready = 0; frame_done = 0; fill_words = '0;
  endtask

  task automatic load_cfg(input logic [1:0] lv, input logic slow, input logic sf,
                          input string tag);
    cfg_level = lv; cfg_slow = slow; cfg_sf = sf; cfg_load = 1;
    tick(tag);
    cfg_load = 0;
  endtask

  task automatic finish_frame(input string tag);
    frame_done = 1; fill_words = '0; frame_ready = 0;
    tick(tag);
    frame_done = 0;
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 0; cfg_level = 2'b11; cfg_slow = 1; cfg_sf = 1;
    idle_inputs();
    m_level = 0; m_slow = 0; m_sf = 0; m_grant = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 reset", start_grant, 1'b0);
    rst_n = 1;
    repeat (3) tick("R1 settle");

    // R1: defaults give a fast-link 32 word threshold in cut-through
    fill_words = 10'h01F; tick("R1 below default");
    check("R1 below default", start_grant, 1'b0);
    fill_words = 10'h020; tick("R1 at default");
    check("R1 at default", start_grant, 1'b1);
    finish_frame("R7 clear");
    check("R7 clear", start_grant, 1'b0);

    // R7: frame_done while idle is ignored
    frame_done = 1; tick("R7 done idle"); frame_done = 0;
    check("R7 done idle", start_grant, 1'b0);

    // R2 / R3 / R4 table sweep at threshold-1 and threshold
    for (int s = 0; s < 2; s++) begin
      for (int c = 0; c < 4; c++) begin
        load_cfg(2'(c), 1'(s), 1'b0, "R9 load");
        fill_words = FW'(thr_of(2'(c), 1'(s)) - 1);
        tick(s ? "R2/R4 below" : "R3/R4 below");
        fill_words = FW'(thr_of(2'(c), 1'(s)));
        tick(s ? "R2/R4 at" : "R3/R4 at");
        check(s ? "R2 grant" : "R3 grant", start_grant, 1'b1);
        finish_frame("R7 clear");
      end
    end

    // R5: store-and-forward ignores fill level
    load_cfg(2'd0, 1'b0, 1'b1, "R9 load");
    fill_words = 10'h3FF; tick("R5 full no frame"); tick("R5 full no frame");
    check("R5 waits", start_grant, 1'b0);
    frame_ready = 1; tick("R5 frame");
    check("R5 frame", start_grant, 1'b1);
    finish_frame("R7 clear");

    // R6: short frame under cut-through
    load_cfg(2'd3, 1'b0, 1'b0, "R9 load");
    fill_words = 10'd5; frame_ready = 1; tick("R6 short frame");
    check("R6 short frame", start_grant, 1'b1);
    frame_ready = 0;

    // R8: reload while granted, grant unaffected; new table for next frame
    load_cfg(2'd0, 1'b1, 1'b1, "R8 load during frame");
    fill_words = '0; tick("R8 hold"); tick("R8 hold");
    check("R8 hold", start_grant, 1'b1);
    load_cfg(2'd0, 1'b1, 1'b0, "R8 load during frame");
    finish_frame("R7 clear");
    fill_words = 10'd17; tick("R8 next frame below");
    fill_words = 10'd18; tick("R8 next frame at");
    check("R8 next frame", start_grant, 1'b1);
    finish_frame("R7 clear");

    // R9: config inputs without load are ignored (stays slow level 0)
    cfg_level = 2'd3; cfg_slow = 1'b0; cfg_sf = 1'b1;
    fill_words = 10'd18; tick("R9 no load");
    check("R9 no load", start_grant, 1'b1);
    finish_frame("R7 clear");

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      string tg;
      cfg_load    = (($urandom % 16) == 0);
      cfg_level   = 2'($urandom);
      cfg_slow    = 1'($urandom);
      cfg_sf      = (($urandom % 4) == 0);
      fill_words  = FW'($urandom % 300);
      frame_ready = (($urandom % 10) == 0);
      frame_done  = (($urandom % 8) == 0);
      tg = m_grant ? "R7 random" : (m_sf ? "R5 random" : "R4 random");
      tick(tg);
    end
    idle_inputs();
    summary();
  end

endmodule